// File: doc/BRIEF.md
# Accumulator ALU with Condition Flags

This block is the arithmetic and logic stage of a small 8-bit accumulator machine. Each cycle it takes an operation code, the accumulator byte, a memory operand byte, the low and high index bytes and a carry input. It forms the result combinationally on `res_lo` and, for multiply and divide, on `res_hi`. Alongside the result it computes the next condition flags. Those flags are written into an 8-bit flag register on the next rising clock edge, but only when `op_valid` is high.

Every operation has its own rule for which flags change, which are forced and which keep their value. The decimal adjust operation reads the half-carry and carry bits already held in the flag register, so a decimal add followed by an adjust gives packed-BCD results. Multiply returns the 16-bit product split across two bytes. Divide returns the quotient and remainder, and it saturates with the carry flag set when the quotient cannot be formed.

Top module: `alu8_ccr`

## Requirements
- R1: The flag register holds V at bit 7, H at bit 4, I at bit 3, N at bit 2, Z at bit 1 and C at bit 0. Bits 6 and 5 always read 1. Reset loads 8'h68. No operation changes I.
- R2: The flag register is written only on a rising edge where `op_valid` is 1; at other times it holds. Op codes 25 to 31 are unused: they give 0 on both result outputs and leave the flags unchanged. `res_hi` is 0 for every operation except multiply and divide.
- R3: Add (op 0) and add-with-carry (op 1, which adds `carry_in`) return A+M(+cin). C is set to the carry out of bit 7 and H to the carry out of bit 3. V is set when A and M have the same sign and the result sign differs from it. N and Z follow the result.
- R4: Subtract (op 2), subtract-with-borrow (op 3, which also subtracts `carry_in`) and compare (op 4) form A-M(-cin). C is set to the borrow. V is set when the signs of A and M differ and the result sign differs from A. N and Z follow the difference, and H is unchanged. Compare outputs A unchanged.
- R5: AND (op 5), OR (op 6), XOR (op 7), bit test (op 8, outputs A), load (op 9, outputs M) and test (op 10, outputs A) force V to 0 and set N and Z from the computed value. H and C are unchanged.
- R6: Shift left (op 11), arithmetic shift right (op 12), logical shift right (op 13), rotate left (op 14) and rotate right (op 15) all go through C. Rotates take the old carry from `carry_in`. C receives the bit shifted out, N takes the result bit 7 (always 0 for the logical shift right), Z follows the result and V = N xor C.
- R7: One's complement (op 16) forces C to 1 and V to 0. Negate (op 17) gives 0-A, with C = (result != 0) and V = (result == 8'h80). Increment (op 18) and decrement (op 19) leave C unchanged; V is set on A = 8'h7F and A = 8'h80 respectively. N and Z follow the result for all four.
- R8: Clear (op 20) outputs 0 and forces V to 0, N to 0 and Z to 1. H and C are unchanged.
- R9: Decimal adjust (op 21) adds 8'h06 when A[3:0] > 9 or the stored H is 1. It adds 8'h60 when A > 8'h99 or the stored C is 1, and sets C exactly in that second case. N and Z follow the result, and V and H are left as they were.
- R10: Nibble swap (op 22) outputs {A[3:0], A[7:4]} and changes no flag.
- R11: Multiply (op 23) outputs the product X*A, with the high byte on `res_hi` and the low byte on `res_lo`. It clears H and C; V, N and Z are unchanged.
- R12: Divide (op 24) divides {H byte, A} by X. When X != 0 and H byte < X, it outputs the quotient on `res_lo` and the remainder on `res_hi`, clears C and sets Z from the quotient.
- R13: When divide has X = 0 or H byte >= X, both result bytes are 8'hFF, C is set and Z is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Commit the computed flags at the next edge |
| op_sel | input | 5 | Operation code (see requirements) |
| opnd_a | input | 8 | Accumulator operand |
| opnd_m | input | 8 | Memory operand |
| x_byte | input | 8 | Index low byte (multiplier / divisor) |
| h_byte | input | 8 | Index high byte (dividend high) |
| carry_in | input | 1 | Carry for add/subtract with carry and rotates |
| res_lo | output | 8 | Result byte |
| res_hi | output | 8 | Product high byte or remainder |
| ccr_q | output | 8 | Registered condition flags |

## Verification
The result bytes are combinational, so they are valid in the same cycle that the operands are applied. A new flag value shows up on `ccr_q` one rising edge after an operation presented with `op_valid` high. The bench applies inputs on the falling edge and then compares both result bytes against its reference model. In that same falling-edge window it compares `ccr_q` against the flags the model committed at the previous rising edge, and it tags any flag mismatch with the requirement of the operation that produced it. Decimal adjust depends on stored flags, so the model carries its own flag state from cycle to cycle, including through cycles where `op_valid` is low.

// File: rtl/alu8_pkg.sv
`timescale 1ns/1ps
package alu8_pkg;
  localparam int unsigned ALU_W = 8;
  localparam int unsigned NIB_W = ALU_W / 2;
  localparam int unsigned OP_W  = 5;

  localparam int unsigned FV = 7;
  localparam int unsigned FH = 4;
  localparam int unsigned FI = 3;
  localparam int unsigned FN = 2;
  localparam int unsigned FZ = 1;
  localparam int unsigned FC = 0;

  localparam logic [ALU_W-1:0] CCR_RESET = 8'h68;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_SBC  = 5'd3,
    OP_CMP  = 5'd4,  OP_AND  = 5'd5,  OP_OR   = 5'd6,  OP_XOR  = 5'd7,
    OP_BIT  = 5'd8,  OP_LOAD = 5'd9,  OP_TST  = 5'd10, OP_ASL  = 5'd11,
    OP_ASR  = 5'd12, OP_LSR  = 5'd13, OP_ROL  = 5'd14, OP_ROR  = 5'd15,
    OP_COM  = 5'd16, OP_NEG  = 5'd17, OP_INC  = 5'd18, OP_DEC  = 5'd19,
    OP_CLR  = 5'd20, OP_DAA  = 5'd21, OP_NSA  = 5'd22, OP_MUL  = 5'd23,
    OP_DIV  = 5'd24
  } alu_op_e;
endpackage

// File: rtl/alu8_addsub.sv
`timescale 1ns/1ps
module alu8_addsub #(
  parameter int unsigned W  = 8,
  parameter int unsigned NW = W / 2
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] res,
  output logic         c_out,
  output logic         h_out,
  output logic         v_out
);
  logic [W:0]  full;
  logic [NW:0] low;

  always_comb begin
    if (sub) full = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
    else     full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    low   = {1'b0, a[NW-1:0]} + {1'b0, b[NW-1:0]} + {{NW{1'b0}}, cin};
    res   = full[W-1:0];
    c_out = full[W];
    h_out = low[NW];
    if (sub) v_out = (a[W-1] ^ b[W-1]) & (a[W-1] ^ full[W-1]);
    else     v_out = ~(a[W-1] ^ b[W-1]) & (a[W-1] ^ full[W-1]);
  end
endmodule

// File: rtl/alu8_shift.sv
`timescale 1ns/1ps
module alu8_shift
  import alu8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         c_out
);
  always_comb begin
    res   = a;
    c_out = 1'b0;
    case (op)
      OP_ASL: begin res = {a[W-2:0], 1'b0};   c_out = a[W-1]; end
      OP_ASR: begin res = {a[W-1], a[W-1:1]}; c_out = a[0];   end
      OP_LSR: begin res = {1'b0, a[W-1:1]};   c_out = a[0];   end
      OP_ROL: begin res = {a[W-2:0], cin};    c_out = a[W-1]; end
      OP_ROR: begin res = {cin, a[W-1:1]};    c_out = a[0];   end
      default: begin res = a; c_out = 1'b0; end
    endcase
  end
endmodule

// File: rtl/alu8_muldiv.sv
`timescale 1ns/1ps
module alu8_muldiv #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] x,
  input  logic [W-1:0] h,
  output logic [W-1:0] prod_lo,
  output logic [W-1:0] prod_hi,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem,
  output logic         div_err
);
  localparam int unsigned DW = 2 * W;

  logic [DW-1:0] product;
  logic [DW-1:0] dividend;
  logic [DW-1:0] divisor;
  logic [DW-1:0] q_full;
  logic [DW-1:0] r_full;

  always_comb begin
    product  = {{W{1'b0}}, a} * {{W{1'b0}}, x};
    prod_lo  = product[W-1:0];
    prod_hi  = product[DW-1:W];
    dividend = {h, a};
    div_err  = (x == '0) || (h >= x);
    divisor  = div_err ? {{(DW-1){1'b0}}, 1'b1} : {{W{1'b0}}, x};
    q_full   = dividend / divisor;
    r_full   = dividend % divisor;
    quo      = div_err ? {W{1'b1}} : q_full[W-1:0];
    rem      = div_err ? {W{1'b1}} : r_full[W-1:0];
  end
endmodule

// File: rtl/alu8_flag_reg.sv
`timescale 1ns/1ps
module alu8_flag_reg #(
  parameter int unsigned     W   = 8,
  parameter logic [W-1:0]    RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RST;
    else if (en) q <= d;
  end

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q));

  // R1
  fixed_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q[6:5] == 2'b11);
endmodule

// File: rtl/alu8_ccr.sv
`timescale 1ns/1ps
module alu8_ccr
  import alu8_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [OP_W-1:0]  op_sel,
  input  logic [ALU_W-1:0] opnd_a,
  input  logic [ALU_W-1:0] opnd_m,
  input  logic [ALU_W-1:0] x_byte,
  input  logic [ALU_W-1:0] h_byte,
  input  logic             carry_in,
  output logic [ALU_W-1:0] res_lo,
  output logic [ALU_W-1:0] res_hi,
  output logic [ALU_W-1:0] ccr_q
);
  alu_op_e          op;
  logic             as_sub;
  logic             as_cin;
  logic [ALU_W-1:0] as_res;
  logic             as_c, as_h, as_v;
  logic [ALU_W-1:0] sh_res;
  logic             sh_c;
  logic [ALU_W-1:0] p_lo, p_hi, d_quo, d_rem;
  logic             d_err;
  logic [ALU_W-1:0] ccr_d;
  logic [ALU_W-1:0] val;
  logic [ALU_W-1:0] daa_corr;
  logic             daa_up;

  assign op     = alu_op_e'(op_sel);
  assign as_sub = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP);
  assign as_cin = ((op == OP_ADC) || (op == OP_SBC)) ? carry_in : 1'b0;

  alu8_addsub #(.W(ALU_W), .NW(NIB_W)) u_addsub (
    .a(opnd_a), .b(opnd_m), .cin(as_cin), .sub(as_sub),
    .res(as_res), .c_out(as_c), .h_out(as_h), .v_out(as_v)
  );

  alu8_shift #(.W(ALU_W)) u_shift (
    .op(op), .a(opnd_a), .cin(carry_in), .res(sh_res), .c_out(sh_c)
  );

  alu8_muldiv #(.W(ALU_W)) u_muldiv (
    .a(opnd_a), .x(x_byte), .h(h_byte),
    .prod_lo(p_lo), .prod_hi(p_hi), .quo(d_quo), .rem(d_rem), .div_err(d_err)
  );

  // Next-state logic: result bytes and next flag value
  always_comb begin
    ccr_d    = ccr_q;
    res_lo   = '0;
    res_hi   = '0;
    val      = '0;
    daa_up   = 1'b0;
    daa_corr = '0;
    case (op)
      OP_ADD, OP_ADC: begin
        val = as_res; res_lo = as_res;
        ccr_d[FC] = as_c; ccr_d[FH] = as_h; ccr_d[FV] = as_v;
        ccr_d[FN] = val[ALU_W-1]; ccr_d[FZ] = (val == '0);
      end
      OP_SUB, OP_SBC, OP_CMP: begin
        val = as_res;
        res_lo = (op == OP_CMP) ? opnd_a : as_res;
        ccr_d[FC] = as_c; ccr_d[FV] = as_v;
        ccr_d[FN] = val[ALU_W-1]; ccr_d[FZ] = (val == '0);
      end
      OP_AND, OP_OR, OP_XOR, OP_BIT, OP_LOAD, OP_TST: begin
        case (op)
          OP_AND:  val = opnd_a & opnd_m;
          OP_OR:   val = opnd_a | opnd_m;
          OP_XOR:  val = opnd_a ^ opnd_m;
          OP_BIT:  val = opnd_a & opnd_m;
          OP_LOAD: val = opnd_m;
          default: val = opnd_a;
        endcase
        res_lo = ((op == OP_BIT) || (op == OP_TST)) ? opnd_a : val;
        ccr_d[FV] = 1'b0;
        ccr_d[FN] = val[ALU_W-1]; ccr_d[FZ] = (val == '0);
      end
      OP_ASL, OP_ASR, OP_LSR, OP_ROL, OP_ROR: begin
        val = sh_res; res_lo = sh_res;
        ccr_d[FC] = sh_c;
        ccr_d[FN] = sh_res[ALU_W-1];
        ccr_d[FZ] = (sh_res == '0);
        ccr_d[FV] = sh_res[ALU_W-1] ^ sh_c;
      end
      OP_COM: begin
        val = ~opnd_a; res_lo = val;
        ccr_d[FC] = 1'b1; ccr_d[FV] = 1'b0;
        ccr_d[FN] = val[ALU_W-1]; ccr_d[FZ] = (val == '0);
      end
      OP_NEG: begin
        val = '0 - opnd_a; res_lo = val;
        ccr_d[FC] = (val != '0);
        ccr_d[FV] = (val == {1'b1, {(ALU_W-1){1'b0}}});
        ccr_d[FN] = val[ALU_W-1]; ccr_d[FZ] = (val == '0);
      end
      OP_INC: begin
        val = opnd_a + 1'b1; res_lo = val;
        ccr_d[FV] = (opnd_a == {1'b0, {(ALU_W-1){1'b1}}});
        ccr_d[FN] = val[ALU_W-1]; ccr_d[FZ] = (val == '0);
      end
      OP_DEC: begin
        val = opnd_a - 1'b1; res_lo = val;
        ccr_d[FV] = (opnd_a == {1'b1, {(ALU_W-1){1'b0}}});
        ccr_d[FN] = val[ALU_W-1]; ccr_d[FZ] = (val == '0);
      end
      OP_CLR: begin
        res_lo = '0;
        ccr_d[FV] = 1'b0; ccr_d[FN] = 1'b0; ccr_d[FZ] = 1'b1;
      end
      OP_DAA: begin
        if ((opnd_a[NIB_W-1:0] > 4'd9) || ccr_q[FH]) daa_corr[NIB_W-1:0] = 4'h6;
        daa_up = (opnd_a > 8'h99) || ccr_q[FC];
        if (daa_up) daa_corr[ALU_W-1:NIB_W] = 4'h6;
        val = opnd_a + daa_corr; res_lo = val;
        ccr_d[FC] = daa_up;
        ccr_d[FN] = val[ALU_W-1]; ccr_d[FZ] = (val == '0);
      end
      OP_NSA: begin
        res_lo = {opnd_a[NIB_W-1:0], opnd_a[ALU_W-1:NIB_W]};
      end
      OP_MUL: begin
        res_lo = p_lo; res_hi = p_hi;
        ccr_d[FH] = 1'b0; ccr_d[FC] = 1'b0;
      end
      OP_DIV: begin
        res_lo = d_quo; res_hi = d_rem;
        ccr_d[FC] = d_err;
        ccr_d[FZ] = (d_quo == '0);
      end
      default: begin
        res_lo = '0; res_hi = '0;
      end
    endcase
    ccr_d[6:5] = 2'b11;
    ccr_d[FI]  = ccr_q[FI];
  end

  // Flag register
  alu8_flag_reg #(.W(ALU_W), .RST(CCR_RESET)) u_flags (
    .clk(clk), .rst_n(rst_n), .en(op_valid), .d(ccr_d), .q(ccr_q)
  );

  // R11
  mul_clears_hc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == OP_MUL) |=> (!ccr_q[FH] && !ccr_q[FC]));

  // R10
  nsa_no_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == OP_NSA) |=> $stable(ccr_q));

  // R7
  com_forces_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == OP_COM) |=> (ccr_q[FC] && !ccr_q[FV]));

  // R5
  logic_v_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel >= OP_AND && op_sel <= OP_TST) |=> !ccr_q[FV]);

  // R8
  clr_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == OP_CLR) |=> (ccr_q[FZ] && !ccr_q[FN] && !ccr_q[FV]));

  // R13
  div_zero_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_DIV && x_byte == '0) |-> (res_lo == '1 && res_hi == '1));

  // R1
  imask_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(ccr_q[FI]));
endmodule

// File: tb/sim_alu8_ccr.sv
`timescale 1ns/1ps
module sim_alu8_ccr;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 100000;
  localparam int N_RANDOM = 3000;

  logic       clk;
  logic       rst_n;
  logic       op_valid;
  logic [4:0] op_sel;
  logic [7:0] opnd_a, opnd_m, x_byte, h_byte;
  logic       carry_in;
  logic [7:0] res_lo, res_hi, ccr_q;

  int n_cmp = 0;
  int n_bad = 0;
  int model_ccr = 'h68;
  string pend_tag = "R1";
  bit done = 0;

  alu8_ccr u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .opnd_a(opnd_a), .opnd_m(opnd_m), .x_byte(x_byte), .h_byte(h_byte),
    .carry_in(carry_in), .res_lo(res_lo), .res_hi(res_hi), .ccr_q(ccr_q)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int sb(int f, int k, int b);
    return (f & ~(1 << k)) | ((b != 0 ? 1 : 0) << k);
  endfunction

  function automatic string tag_of(int op, int x, int h);
    if (op <= 1) return "R3";
    if (op <= 4) return "R4";
    if (op <= 10) return "R5";
    if (op <= 15) return "R6";
    if (op <= 19) return "R7";
    if (op == 20) return "R8";
    if (op == 21) return "R9";
    if (op == 22) return "R10";
    if (op == 23) return "R11";
    if (op == 24) return (x == 0 || h >= x) ? "R13" : "R12";
    return "R2";
  endfunction

  // Behavioural reference: results and next flags
  task automatic model(input int op, input int a, input int m, input int x,
                       input int h, input int ci, input int f_in,
                       output int lo, output int hi, output int f);
    int r, s, c, n, corr, up, d;
    f = f_in; lo = 0; hi = 0; r = 0;
    case (op)
      0, 1: begin
        c = (op == 1) ? ci : 0;
        s = a + m + c; r = s & 255; lo = r;
        f = sb(f, 0, s > 255);
        f = sb(f, 4, ((a & 15) + (m & 15) + c) > 15);
        f = sb(f, 7, ((~(a ^ m)) & (a ^ r) & 128) != 0);
        f = sb(f, 2, r >> 7); f = sb(f, 1, r == 0);
      end
      2, 3, 4: begin
        c = (op == 3) ? ci : 0;
        s = a - m - c; r = s & 255;
        lo = (op == 4) ? a : r;
        f = sb(f, 0, s < 0);
        f = sb(f, 7, ((a ^ m) & (a ^ r) & 128) != 0);
        f = sb(f, 2, r >> 7); f = sb(f, 1, r == 0);
      end
      5, 6, 7, 8, 9, 10: begin
        case (op)
          5: r = a & m; 6: r = a | m; 7: r = a ^ m;
          8: r = a & m; 9: r = m; default: r = a;
        endcase
        lo = (op == 8 || op == 10) ? a : r;
        f = sb(f, 7, 0); f = sb(f, 2, r >> 7); f = sb(f, 1, r == 0);
      end
      11, 12, 13, 14, 15: begin
        case (op)
          11: begin r = (a << 1) & 255; c = a >> 7; end
          12: begin r = (a >> 1) | (a & 128); c = a & 1; end
          13: begin r = a >> 1; c = a & 1; end
          14: begin r = ((a << 1) & 255) | ci; c = a >> 7; end
          default: begin r = (a >> 1) | (ci << 7); c = a & 1; end
        endcase
        lo = r; n = r >> 7;
        f = sb(f, 0, c); f = sb(f, 2, n); f = sb(f, 1, r == 0); f = sb(f, 7, n ^ c);
      end
      16: begin r = (~a) & 255; lo = r; f = sb(f, 0, 1); f = sb(f, 7, 0);
                f = sb(f, 2, r >> 7); f = sb(f, 1, r == 0); end
      17: begin r = (256 - a) & 255; lo = r; f = sb(f, 0, r != 0); f = sb(f, 7, r == 128);
                f = sb(f, 2, r >> 7); f = sb(f, 1, r == 0); end
      18: begin r = (a + 1) & 255; lo = r; f = sb(f, 7, a == 127);
                f = sb(f, 2, r >> 7); f = sb(f, 1, r == 0); end
      19: begin r = (a + 255) & 255; lo = r; f = sb(f, 7, a == 128);
                f = sb(f, 2, r >> 7); f = sb(f, 1, r == 0); end
      20: begin lo = 0; f = sb(f, 7, 0); f = sb(f, 2, 0); f = sb(f, 1, 1); end
      21: begin
        corr = 0;
        if ((a & 15) > 9 || ((f_in >> 4) & 1) != 0) corr = corr + 6;
        up = (a > 'h99 || (f_in & 1) != 0) ? 1 : 0;
        if (up != 0) corr = corr + 'h60;
        r = (a + corr) & 255; lo = r;
        f = sb(f, 0, up); f = sb(f, 2, r >> 7); f = sb(f, 1, r == 0);
      end
      22: lo = ((a & 15) << 4) | (a >> 4);
      23: begin s = x * a; lo = s & 255; hi = s >> 8; f = sb(f, 4, 0); f = sb(f, 0, 0); end
      24: begin
        d = h * 256 + a;
        if (x == 0 || h >= x) begin lo = 255; hi = 255; f = sb(f, 0, 1); end
        else begin lo = d / x; hi = d % x; f = sb(f, 0, 0); end
        f = sb(f, 1, lo == 0);
      end
      default: begin lo = 0; hi = 0; end
    endcase
  endtask

  task automatic report(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  task automatic step(input int op, input int a, input int m, input int x,
                      input int h, input int ci, input int vld);
    int lo, hi, f;
    @(negedge clk);
    op_sel = op[4:0]; opnd_a = a[7:0]; opnd_m = m[7:0];
    x_byte = x[7:0]; h_byte = h[7:0]; carry_in = ci[0]; op_valid = vld[0];
    #1;
    model(op, a, m, x, h, ci, model_ccr, lo, hi, f);
    report(pend_tag, "flags", int'(ccr_q), model_ccr);
    report(tag_of(op, x, h), "res_lo", int'(res_lo), lo);
    report(tag_of(op, x, h), "res_hi", int'(res_hi), hi);
    @(posedge clk);
    if (vld != 0) begin
      model_ccr = f;
      pend_tag = tag_of(op, x, h);
    end else begin
      pend_tag = "R2";
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_sel = '0; opnd_a = '0; opnd_m = '0;
    x_byte = '0; h_byte = '0; carry_in = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    report("R1", "reset flags", int'(ccr_q), 'h68);

    // R3: signed overflow with half carry; carry out to zero
    step(0, 'h7F, 'h01, 0, 0, 0, 1);
    step(0, 'hFF, 'h01, 0, 0, 0, 1);
    step(1, 'h10, 'h0F, 0, 0, 1, 1);
    // R4: overflow on subtract, borrow, compare equal keeps A
    step(2, 'h80, 'h01, 0, 0, 0, 1);
    step(3, 'h00, 'h00, 0, 0, 1, 1);
    step(4, 'h42, 'h42, 0, 0, 0, 1);
    // R5: logic group, bit test outputs A
    step(8, 'hF0, 'h0F, 0, 0, 0, 1);
    step(9, 'h00, 'h80, 0, 0, 0, 1);
    // R6: shifts and rotates through carry
    step(13, 'h01, 0, 0, 0, 0, 1);
    step(14, 'h80, 0, 0, 0, 1, 1);
    step(15, 'h01, 0, 0, 0, 1, 1);
    step(12, 'h81, 0, 0, 0, 0, 1);
    // R7
    step(16, 'hFF, 0, 0, 0, 0, 1);
    step(17, 'h80, 0, 0, 0, 0, 1);
    step(17, 'h00, 0, 0, 0, 0, 1);
    step(18, 'h7F, 0, 0, 0, 0, 1);
    step(19, 'h80, 0, 0, 0, 0, 1);
    // R8
    step(20, 'h55, 0, 0, 0, 0, 1);
    // R9: BCD add 0x19+0x28 then adjust; 0x9A adjust
    step(0, 'h19, 'h28, 0, 0, 0, 1);
    step(21, 'h41, 0, 0, 0, 0, 1);
    step(0, 'h01, 'h01, 0, 0, 0, 1);
    step(21, 'h9A, 0, 0, 0, 0, 1);
    // R10
    step(22, 'hA5, 0, 0, 0, 0, 1);
    // R11
    step(23, 'hFF, 0, 'hFF, 0, 0, 1);
    // R12
    step(24, 'h00, 0, 'h10, 'h01, 0, 1);
    step(24, 'h07, 0, 'h03, 'h00, 0, 1);
    step(24, 'h02, 0, 'h03, 'h00, 0, 1);
    // R13: divide by zero, quotient overflow
    step(24, 'h12, 0, 'h00, 'h00, 0, 1);
    step(24, 'h00, 0, 'h03, 'h05, 0, 1);
    // R2: no commit, unused code
    step(0, 'hFF, 'hFF, 0, 0, 1, 0);
    step(31, 'h12, 'h34, 0, 0, 1, 1);
    step(27, 'h12, 'h34, 0, 0, 1, 0);

    for (int i = 0; i < N_RANDOM; i++) begin
      step($urandom_range(0, 31), $urandom_range(0, 255), $urandom_range(0, 255),
           $urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 1),
           ($urandom_range(0, 7) != 0) ? 1 : 0);
    end
    step(22, 0, 0, 0, 0, 0, 0);
    // R1: fixed ones and interrupt mask never disturbed
    report("R1", "bits 6:5,3", int'(ccr_q & 8'h68), 'h68);
    done = 1;
    finish_run();
  end
endmodule